// File: doc/BRIEF.md
# Ensemble Vote Escalation Controller

This block steers an ensemble of up to seven one-class base learners during inference so that most of them can sit idle while the monitored machine looks healthy. It keeps a count N of active learners, always odd, and drives an enable mask that switches on learners 0 to N-1. The other learners may then have their clocks gated. For each evaluated sample, every learner reports one bit saying whether its reconstruction error crossed its own threshold. A done strobe marks those bits as valid, and the controller takes a strict majority vote over the enabled learners.

A healthy vote shrinks the active set by two, never below one, and tells the surrounding logic to move on to the next sample. A faulty vote grows the set by two and asks for the same sample to be evaluated again by the larger set. When the set is already at its configured ceiling K, a faulty vote raises a sticky anomaly flag instead. That flag holds until an explicit clear, and the controller ignores further strobes while it is set. Computing errors, setting thresholds and switching power are handled elsewhere. This block only produces enables and commands.

Top module: `vote_escalation_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the active count is 1, `learner_en` is 7'b0000001, `anomaly` is 0, and `recheck` and `advance` are both 0.
- R2: `learner_en` is thermometer coded: bit i is 1 exactly when i < N, where N is the active count. N only takes the values 1, 3, 5 or 7.
- R3: An error flag from a learner whose enable bit is 0 has no effect on the vote.
- R4: The vote is faulty when the number T of enabled learners with their error flag at 1 satisfies T >= (N+1)/2. Otherwise it is healthy.
- R5: A healthy vote on a strobe raises `advance` for exactly the one cycle after the strobe's clock edge. In that same cycle, N becomes N-2, or stays at 1 if it was 1.
- R6: A faulty vote with N below the effective ceiling raises `recheck` for exactly the one cycle after the strobe's clock edge. In that same cycle, N becomes N+2.
- R7: A faulty vote with N at or above the effective ceiling sets `anomaly` in the cycle after the strobe's clock edge. It raises neither command and leaves N unchanged.
- R8: Once set, `anomaly` stays at 1 until a clear or a reset. While it is set, strobes produce no command and do not change N.
- R9: `anomaly_clr` drives `anomaly` to 0 and N to 1 at the next clock edge. It takes precedence over a strobe in the same cycle, and that strobe is dropped.
- R10: The effective ceiling is derived from `cfg_limit`: the value is first clamped to 7, an even value is then reduced by one, and 0 becomes 1.
- R11: A cycle without a strobe leaves N unchanged and produces no command, whatever the error flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_limit | input | 3 | Requested ceiling K on the active count |
| sample_done | input | 1 | One-cycle strobe: the error flags are valid for the current sample |
| err_flags | input | 7 | Per-learner error-above-threshold bits |
| anomaly_clr | input | 1 | Clears the sticky anomaly and restarts at one learner |
| learner_en | output | 7 | Thermometer enable mask of the active learners |
| active_cnt | output | 3 | Current active count N |
| recheck | output | 1 | One-cycle command: evaluate the same sample again |
| advance | output | 1 | One-cycle command: move on to the next sample |
| anomaly | output | 1 | Sticky anomaly flag |

## Verification
The bench targets the majority boundary at every set size, for example three faults out of five and three out of seven. A design that uses a non-strict or off-by-one threshold would grow where it should shrink. It sets error flags on disabled learners, which a design without masking would count toward a false escalation. It also checks the shrink floor at one learner, odd rounding of an even or zero ceiling, and a clear that arrives together with a strobe. Each of these would show up as a wrong count, a stray `advance`, or an anomaly raised early or late. Strobes sent while the anomaly is held must leave the count and the commands untouched, which catches a design that keeps voting after declaring a fault.

// File: rtl/vote_esc_pkg.sv
// Shared types for the ensemble vote escalation controller.
package vote_esc_pkg;
    // Outcome of one strobe as decided by the top-level control.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_SHRINK = 2'd1,
        ACT_GROW   = 2'd2,
        ACT_FLAG   = 2'd3
    } vote_act_e;
endpackage

// File: rtl/vote_limit_norm.sv
// Turns the requested ceiling into a usable odd ceiling.
// Assumes: the request may be any value that fits in CNT_W bits.
module vote_limit_norm #(
    parameter int MAX_LEARNERS = 7,
    parameter int CNT_W        = 3
) (
    input  logic [CNT_W-1:0] cfg_limit,
    output logic [CNT_W-1:0] eff_limit
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_LEARNERS);

    logic [CNT_W-1:0] clamped;

    // Clamp the request to the ensemble size, then force it odd and non-zero.
    always_comb begin
        clamped = (cfg_limit > MAX_CNT) ? MAX_CNT : cfg_limit;
        if (clamped == '0)
            eff_limit = CNT_W'(1);
        else if (!clamped[0])
            eff_limit = clamped - CNT_W'(1);
        else
            eff_limit = clamped;
    end
endmodule

// File: rtl/vote_thermo_mask.sv
// Expands an active count into a thermometer enable mask (lanes below count on).
// Assumes: count never exceeds LANES.
module vote_thermo_mask #(
    parameter int LANES = 7,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] count,
    output logic [LANES-1:0] mask
);
    // One comparator per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask[g] = ({1'b0, count} > (CNT_W+1)'(g));
    end
endmodule

// File: rtl/vote_tally.sv
// Masks the error flags with the enable mask, counts them and applies a strict majority.
// Assumes: active_cnt is odd, so 2T > N is the same test as T >= (N+1)/2.
module vote_tally #(
    parameter int LANES = 7,
    parameter int CNT_W = 3
) (
    input  logic [LANES-1:0] err_flags,
    input  logic [LANES-1:0] en_mask,
    input  logic [CNT_W-1:0] active_cnt,
    output logic             fault
);
    logic [LANES-1:0] live;
    logic [CNT_W:0]   tally;

    assign live = err_flags & en_mask;

    // Population count of the flags that belong to enabled learners.
    always_comb begin
        tally = '0;
        for (int i = 0; i < LANES; i++)
            tally = tally + {{CNT_W{1'b0}}, live[i]};
    end

    // Strict majority over the active learners.
    assign fault = ({tally, 1'b0} > {2'b00, active_cnt});
endmodule

// File: rtl/vote_escalation_ctrl.sv
// Grows or shrinks the set of active base learners in steps of two from a majority
// vote, and raises a sticky anomaly once the full set still votes faulty.
// Assumes: sample_done is a single-cycle strobe, and err_flags are valid with it.
module vote_escalation_ctrl
    import vote_esc_pkg::*;
#(
    parameter int MAX_LEARNERS = 7,
    localparam int CNT_W = $clog2(MAX_LEARNERS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        cfg_limit,
    input  logic                    sample_done,
    input  logic [MAX_LEARNERS-1:0] err_flags,
    input  logic                    anomaly_clr,
    output logic [MAX_LEARNERS-1:0] learner_en,
    output logic [CNT_W-1:0]        active_cnt,
    output logic                    recheck,
    output logic                    advance,
    output logic                    anomaly
);
    logic [CNT_W-1:0] cnt_q;
    logic             anomaly_q;
    logic             recheck_q;
    logic             advance_q;
    logic [CNT_W-1:0] eff_limit;
    logic             fault;
    vote_act_e        act;

    vote_limit_norm #(.MAX_LEARNERS(MAX_LEARNERS), .CNT_W(CNT_W)) u_limit (
        .cfg_limit (cfg_limit),
        .eff_limit (eff_limit)
    );

    vote_thermo_mask #(.LANES(MAX_LEARNERS), .CNT_W(CNT_W)) u_mask (
        .count (cnt_q),
        .mask  (learner_en)
    );

    vote_tally #(.LANES(MAX_LEARNERS), .CNT_W(CNT_W)) u_tally (
        .err_flags  (err_flags),
        .en_mask    (learner_en),
        .active_cnt (cnt_q),
        .fault      (fault)
    );

    // Decide what this cycle's strobe does; clear and held anomaly suppress it.
    always_comb begin
        act = ACT_HOLD;
        if (sample_done && !anomaly_q && !anomaly_clr) begin
            if (!fault)
                act = ACT_SHRINK;
            else if (cnt_q < eff_limit)
                act = ACT_GROW;
            else
                act = ACT_FLAG;
        end
    end

    // Update the active count, command pulses and sticky anomaly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= CNT_W'(1);
            anomaly_q <= 1'b0;
            recheck_q <= 1'b0;
            advance_q <= 1'b0;
        end else begin
            recheck_q <= (act == ACT_GROW);
            advance_q <= (act == ACT_SHRINK);
            if (anomaly_clr) begin
                anomaly_q <= 1'b0;
                cnt_q     <= CNT_W'(1);
            end else begin
                case (act)
                    ACT_SHRINK: cnt_q <= (cnt_q > CNT_W'(1)) ? cnt_q - CNT_W'(2) : CNT_W'(1);
                    ACT_GROW:   cnt_q <= cnt_q + CNT_W'(2);
                    ACT_FLAG:   anomaly_q <= 1'b1;
                    default:    ;
                endcase
            end
        end
    end

    assign active_cnt = cnt_q;
    assign recheck    = recheck_q;
    assign advance    = advance_q;
    assign anomaly    = anomaly_q;
endmodule

// File: rtl/vote_escalation_ctrl_chk.sv
// Property checker for the vote escalation controller, attached through bind.
// Assumes: observes only the ports of the controller.
module vote_escalation_ctrl_chk #(
    parameter int MAX_LEARNERS = 7,
    localparam int CNT_W = $clog2(MAX_LEARNERS + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_done,
    input logic                    anomaly_clr,
    input logic [MAX_LEARNERS-1:0] learner_en,
    input logic [CNT_W-1:0]        active_cnt,
    input logic                    recheck,
    input logic                    advance,
    input logic                    anomaly
);
    assert_thermo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((((learner_en + 1'b1) & learner_en) == '0) &&
         ($countones(learner_en) == int'(active_cnt))));

    assert_odd_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active_cnt[0]);

    assert_shrink_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (active_cnt == (($past(active_cnt) > CNT_W'(1)) ?
                                    $past(active_cnt) - CNT_W'(2) : CNT_W'(1))));

    assert_grow_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recheck |-> (active_cnt == $past(active_cnt) + CNT_W'(2)));

    assert_one_command_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(recheck && advance));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (anomaly && !anomaly_clr) |=> anomaly);

    assert_flag_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        anomaly |=> (!recheck && !advance));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        anomaly_clr |=> (!anomaly && active_cnt == CNT_W'(1)));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_done && !anomaly_clr) |=> (!recheck && !advance && $stable(active_cnt)));
endmodule

bind vote_escalation_ctrl vote_escalation_ctrl_chk #(.MAX_LEARNERS(MAX_LEARNERS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_done (sample_done),
    .anomaly_clr (anomaly_clr),
    .learner_en  (learner_en),
    .active_cnt  (active_cnt),
    .recheck     (recheck),
    .advance     (advance),
    .anomaly     (anomaly)
);

// File: tb/vote_escalation_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for the vote escalation controller: one task per scenario.
module vote_escalation_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_limit = 3'd7;
    logic       sample_done = 1'b0;
    logic [6:0] err_flags = '0;
    logic       anomaly_clr = 1'b0;
    logic [6:0] learner_en;
    logic [2:0] active_cnt;
    logic       recheck;
    logic       advance;
    logic       anomaly;

    int checks = 0;
    int errors = 0;
    int exp_n = 1;
    bit exp_anom = 1'b0;

    always #2.5 clk = ~clk;

    vote_escalation_ctrl u_vote_escalation_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_limit   (cfg_limit),
        .sample_done (sample_done),
        .err_flags   (err_flags),
        .anomaly_clr (anomaly_clr),
        .learner_en  (learner_en),
        .active_cnt  (active_cnt),
        .recheck     (recheck),
        .advance     (advance),
        .anomaly     (anomaly)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Ceiling rule of R10.
    function automatic int eff_ceiling(input int cfg);
        int c;
        c = (cfg > 7) ? 7 : cfg;
        if (c == 0) return 1;
        if ((c % 2) == 0) return c - 1;
        return c;
    endfunction

    // Compare every output against the expected count, flag and commands.
    task automatic check_all(input string req, input int rc, input int adv);
        check_eq(req, "active_cnt", int'(active_cnt), exp_n);
        check_eq(req, "learner_en", int'(learner_en), (1 << exp_n) - 1);
        check_eq(req, "anomaly", int'(anomaly), int'(exp_anom));
        check_eq(req, "recheck", int'(recheck), rc);
        check_eq(req, "advance", int'(advance), adv);
    endtask

    // Present one strobe, predict the outcome from R3..R8 and check it.
    task automatic step(input logic [6:0] flags, input string req);
        int t;
        int rc;
        int adv;
        logic [6:0] en;
        en = 7'((1 << exp_n) - 1);
        t = $countones(flags & en);
        rc = 0;
        adv = 0;
        if (!exp_anom) begin
            if (2 * t < exp_n + 1) begin
                adv = 1;
                exp_n = (exp_n > 1) ? exp_n - 2 : 1;
            end else if (exp_n < eff_ceiling(int'(cfg_limit))) begin
                rc = 1;
                exp_n = exp_n + 2;
            end else begin
                exp_anom = 1'b1;
            end
        end
        @(negedge clk);
        err_flags = flags;
        sample_done = 1'b1;
        @(negedge clk);
        sample_done = 1'b0;
        check_all(req, rc, adv);
    endtask

    // Pulse clear, optionally together with a strobe (R9).
    task automatic clear(input bit with_strobe);
        @(negedge clk);
        anomaly_clr = 1'b1;
        sample_done = with_strobe;
        err_flags = '0;
        @(negedge clk);
        anomaly_clr = 1'b0;
        sample_done = 1'b0;
        exp_n = 1;
        exp_anom = 1'b0;
        check_all("R9", 0, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_n = 1;
        exp_anom = 1'b0;
        check_all("R1", 0, 0);
    endtask

    task automatic t_floor;
        step(7'b0000000, "R5");
        check_eq("R5", "count floor", int'(active_cnt), 1);
    endtask

    task automatic t_grow_and_mask;
        step(7'b0000001, "R6");
        check_eq("R2", "mask at three", int'(learner_en), 7);
        // One active fault plus faults on disabled learners: still healthy.
        step(7'b1111001, "R3");
        check_eq("R3", "count after masked vote", int'(active_cnt), 1);
    endtask

    task automatic t_majority_edge;
        step(7'b0000001, "R6");
        step(7'b0000011, "R4");
        check_eq("R4", "two of three grows", int'(active_cnt), 5);
        step(7'b1100111, "R4");
        check_eq("R4", "three of five grows", int'(active_cnt), 7);
        step(7'b0000111, "R4");
        check_eq("R4", "three of seven shrinks", int'(active_cnt), 5);
        step(7'b0000011, "R4");
        check_eq("R4", "two of five shrinks", int'(active_cnt), 3);
        step(7'b0000000, "R5");
    endtask

    task automatic t_flag_and_hold;
        step(7'b0000001, "R6");
        step(7'b0000011, "R6");
        step(7'b0000111, "R6");
        step(7'b0001111, "R7");
        check_eq("R7", "anomaly at ceiling", int'(anomaly), 1);
        step(7'b0000000, "R8");
        step(7'b1111111, "R8");
        check_eq("R8", "count held", int'(active_cnt), 7);
        clear(1'b1);
    endtask

    task automatic t_limits;
        @(negedge clk);
        cfg_limit = 3'd4;
        step(7'b0000001, "R10");
        step(7'b0000011, "R10");
        check_eq("R10", "even limit flags at three", int'(anomaly), 1);
        clear(1'b0);
        cfg_limit = 3'd0;
        step(7'b0000001, "R10");
        check_eq("R10", "zero limit flags at one", int'(anomaly), 1);
        clear(1'b0);
        cfg_limit = 3'd5;
        step(7'b0000001, "R10");
        step(7'b0000011, "R10");
        step(7'b0000111, "R10");
        check_eq("R10", "limit five flags at five", int'(anomaly), 1);
        check_eq("R10", "count stays five", int'(active_cnt), 5);
        clear(1'b0);
        cfg_limit = 3'd7;
    endtask

    task automatic t_idle;
        step(7'b0000001, "R6");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            err_flags = 7'b1111111 >> i;
            @(negedge clk);
            check_all("R11", 0, 0);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_floor();
        t_grow_and_mask();
        t_majority_edge();
        t_flag_and_hold();
        t_limits();
        t_idle();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule